// File: doc/BRIEF.md
# Shared Counter with Per-Core Compare Interrupts

One free-running counter is shared by every core. Each core owns a compare register. When the counter equals that compare value, the core's compare-pending flag is set and stays set. A per-core interrupt mask and a per-core routing register then decide whether the flag drives one of the core's interrupt output pins. Software can stop the counter through a control bit in the shared configuration register. The counter can be loaded only while it is stopped. A read-only copy of the counter sits at a separate address for user-level code.

Every access carries the index of the core that issues it. A local window at word addresses 0x10-0x18 reaches the issuing core's own registers. A remote window at 0x20-0x28 reaches the registers of the core named by the issuer's selector register. Both windows use the same offsets: 0 pending (compare flag in bit 1), 1 mask, 2 mask clear, 3 mask set, 4 routing, 5 selector, 6 identity, 7 compare, 8 compare upper word. The shared registers are 0x00 configuration (bit 0 = stopped), 0x01 counter, 0x02 counter upper word, 0x03 user copy of the counter and 0x04 the user copy's upper word. Read data appears one cycle after the request.

Top module: `shared_cmp_timer`

## Requirements
- R1: Writing bit 0 of address 0x00 stops the counter (1) or restarts it (0), and the bit reads back the current state. While the counter runs it increments by one per clock; while stopped it holds.
- R2: A write to 0x01 loads the counter only while the counter is stopped and is ignored while it runs. Addresses 0x02 and 0x04 read as 0.
- R3: When the counter equals a core's compare value, that core's pending bit (bit 1 at window offset 0) is set. It stays set until the next write to that core's compare register.
- R4: Core c drives pin c*NUM_PINS+p, one cycle after its state allows it, exactly when the pending bit is set, mask bit 1 is set, routing bit 31 (route enable) is set and routing bits [5:0] equal p.
- R5: A write to a core's compare register (offset 7) clears its pending bit, so the routed pin falls, and loads the new compare value.
- R6: Mask bits change only through offset 2, where a 1 clears the bit, and offset 3, where a 1 sets it. Offset 1 reads the mask.
- R7: Remote-window accesses act on the core selected by the issuer's selector (offset 5). A selector write with a value of NUM_CORES or more is ignored.
- R8: The identity register (offset 6) returns the index of the core the window addresses, which is the issuer's own index in the local window.
- R9: Address 0x03 reads the counter value, and writes to it are ignored.
- R10: After reset the counter is 0 and running, every compare is 0xFFFFFFFF, every mask is 0x32, every routing register is 0x80000000, and every pending bit and selector is 0.
- R11: A routing write whose bits [5:0] are NUM_PINS or more is ignored.
- R12: rd_valid and rd_data appear on the clock after a read request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CORE_W | Index of the issuing core |
| req_addr | input | 6 | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_pin | output | NUM_CORES*NUM_PINS | Interrupt pins, core-major |

## Verification
On every cycle the assertions check these rules: the counter steps while running and holds while stopped; a load while stopped takes the written value; the pending flag sets on a match, persists, and clears on a compare write. They also check that a pin is raised only when the flag, the mask and the route enable all allowed it one cycle earlier, that at most one pin per core is high, and that rejected selector and routing writes leave state unchanged. Other behaviours need the bench's scenarios. These are the full core-by-pin routing sweep, the redirection of the remote window, the identity value, the user copy of the counter, the loss of a counter write made while running, and the reset values seen at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 32;
  localparam int MASK_W      = 6;
  localparam int CMP_BIT     = 1;
  localparam int ROUTE_BIT   = 31;
  localparam int PIN_FIELD_W = 6;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  localparam logic [ADDR_W-1:0] A_CFG    = 6'h00;
  localparam logic [ADDR_W-1:0] A_CNT    = 6'h01;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h02;
  localparam logic [ADDR_W-1:0] A_USR    = 6'h03;
  localparam logic [ADDR_W-1:0] A_USR_HI = 6'h04;

  localparam logic [1:0] WIN_LOCAL  = 2'b01;
  localparam logic [1:0] WIN_REMOTE = 2'b10;

  localparam logic [3:0] OFF_PEND  = 4'd0;
  localparam logic [3:0] OFF_MASK  = 4'd1;
  localparam logic [3:0] OFF_MCLR  = 4'd2;
  localparam logic [3:0] OFF_MSET  = 4'd3;
  localparam logic [3:0] OFF_ROUTE = 4'd4;
  localparam logic [3:0] OFF_SEL   = 4'd5;
  localparam logic [3:0] OFF_IDENT = 4'd6;
  localparam logic [3:0] OFF_CMP   = 4'd7;
  localparam logic [3:0] OFF_CMPHI = 4'd8;
  localparam logic [3:0] OFF_LAST  = OFF_CMPHI;

  typedef struct packed {
    logic       cfg;
    logic       cnt;
    logic       cnt_hi;
    logic       usr;
    logic       usr_hi;
    logic       win;
    logic       remote;
    logic [3:0] off;
  } acc_dec_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output acc_dec_t          dec
);
  logic [1:0] win_sel;
  logic [3:0] off;

  assign win_sel = addr[5:4];
  assign off     = addr[3:0];

  always_comb begin
    dec        = '0;
    dec.cfg    = (addr == A_CFG);
    dec.cnt    = (addr == A_CNT);
    dec.cnt_hi = (addr == A_CNT_HI);
    dec.usr    = (addr == A_USR);
    dec.usr_hi = (addr == A_USR_HI);
    dec.off    = off;
    if ((win_sel == WIN_LOCAL || win_sel == WIN_REMOTE) && off <= OFF_LAST) begin
      dec.win    = 1'b1;
      dec.remote = (win_sel == WIN_REMOTE);
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_we,
  input  logic             stop_wd,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wd,
  output logic             stopped,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stopped <= 1'b0;
      count   <= '0;
    end else begin
      if (stop_we) stopped <= stop_wd;
      if (stopped) begin
        if (cnt_we) count <= cnt_wd;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  assert_hold_when_stopped_R1: assert property (@(posedge clk) disable iff (rst)
    (stopped && !cnt_we) |=> (count == $past(count)));
  assert_step_when_running_R1: assert property (@(posedge clk) disable iff (rst)
    (!stopped) |=> (count == $past(count) + 1'b1));
  assert_load_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (stopped && cnt_we) |=> (count == $past(cnt_wd)));
endmodule

// File: rtl/tmr_core_slice.sv
module tmr_core_slice
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_CORES = 2,
  parameter int NUM_PINS  = 6,
  parameter int CORE_W    = 1,
  parameter int PIN_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [3:0]        off,
  input  logic [DATA_W-1:0] wd,
  input  logic [CNT_W-1:0]  count,
  output logic              pend,
  output logic [MASK_W-1:0] mask,
  output logic              route_en,
  output logic [PIN_W-1:0]  route_pin,
  output logic [CORE_W-1:0] sel,
  output logic [CNT_W-1:0]  cmp,
  output logic [NUM_PINS-1:0] irq
);
  logic cmp_we, route_we, route_ok, sel_we, sel_ok, match;

  assign cmp_we   = we && (off == OFF_CMP);
  assign route_we = we && (off == OFF_ROUTE);
  assign sel_we   = we && (off == OFF_SEL);
  assign route_ok = (wd[PIN_FIELD_W-1:0] < PIN_FIELD_W'(NUM_PINS));
  assign sel_ok   = (wd < DATA_W'(NUM_CORES));
  assign match    = (count == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      mask      <= MASK_RST;
      route_en  <= 1'b1;
      route_pin <= '0;
      sel       <= '0;
      cmp       <= '1;
    end else begin
      if (cmp_we) begin
        pend <= 1'b0;
        cmp  <= wd[CNT_W-1:0];
      end else if (match) begin
        pend <= 1'b1;
      end
      if (we && off == OFF_MCLR) mask <= mask & ~wd[MASK_W-1:0];
      if (we && off == OFF_MSET) mask <= mask | wd[MASK_W-1:0];
      if (route_we && route_ok) begin
        route_en  <= wd[ROUTE_BIT];
        route_pin <= wd[PIN_W-1:0];
      end
      if (sel_we && sel_ok) sel <= wd[CORE_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) irq[p] <= 1'b0;
      else     irq[p] <= pend && mask[CMP_BIT] && route_en && (route_pin == PIN_W'(p));
    end
  end

  assert_pend_sets_on_match_R3: assert property (@(posedge clk) disable iff (rst)
    (match && !cmp_we) |=> pend);
  assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (pend && !cmp_we) |=> pend);
  assert_cmp_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
    cmp_we |=> !pend);
  assert_pin_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> $past(pend && mask[CMP_BIT] && route_en));
  assert_one_pin_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));
  assert_sel_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_we && !sel_ok) |=> $stable(sel));
  assert_route_reject_R11: assert property (@(posedge clk) disable iff (rst)
    (route_we && !route_ok) |=> ($stable(route_en) && $stable(route_pin)));
  assert_mask_only_by_set_clr_R6: assert property (@(posedge clk) disable iff (rst)
    !(we && (off == OFF_MCLR || off == OFF_MSET)) |=> $stable(mask));
endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int NUM_PINS  = 6,
  parameter int CNT_W     = 32,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [CORE_W-1:0]             req_core,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic [NUM_CORES*NUM_PINS-1:0] irq_pin
);
  acc_dec_t dec;
  logic wr, rd, stopped;
  logic [CNT_W-1:0]  count;
  logic [CORE_W-1:0] target;

  logic              pend_a  [NUM_CORES];
  logic [MASK_W-1:0] mask_a  [NUM_CORES];
  logic              ren_a   [NUM_CORES];
  logic [PIN_W-1:0]  rpin_a  [NUM_CORES];
  logic [CORE_W-1:0] sel_a   [NUM_CORES];
  logic [CNT_W-1:0]  cmp_a   [NUM_CORES];
  logic [DATA_W-1:0] rd_next;

  tmr_decode u_dec (.addr(req_addr), .dec(dec));

  assign wr     = req_valid && req_write && (int'(req_core) < NUM_CORES);
  assign rd     = req_valid && !req_write;
  assign target = dec.remote ? sel_a[req_core] : req_core;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .stop_we(wr && dec.cfg), .stop_wd(req_wdata[0]),
    .cnt_we(wr && dec.cnt), .cnt_wd(req_wdata[CNT_W-1:0]),
    .stopped(stopped), .count(count)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    tmr_core_slice #(
      .CNT_W(CNT_W), .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS),
      .CORE_W(CORE_W), .PIN_W(PIN_W)
    ) u_slice (
      .clk(clk), .rst(rst),
      .we(wr && dec.win && (target == CORE_W'(g))),
      .off(dec.off), .wd(req_wdata), .count(count),
      .pend(pend_a[g]), .mask(mask_a[g]), .route_en(ren_a[g]),
      .route_pin(rpin_a[g]), .sel(sel_a[g]), .cmp(cmp_a[g]),
      .irq(irq_pin[g*NUM_PINS +: NUM_PINS])
    );
  end

  always_comb begin
    rd_next = '0;
    if (dec.cfg) begin
      rd_next[0] = stopped;
    end else if (dec.cnt || dec.usr) begin
      rd_next = DATA_W'(count);
    end else if (dec.win) begin
      case (dec.off)
        OFF_PEND:  rd_next[CMP_BIT] = pend_a[target];
        OFF_MASK:  rd_next = DATA_W'(mask_a[target]);
        OFF_ROUTE: begin
          rd_next = DATA_W'(rpin_a[target]);
          rd_next[ROUTE_BIT] = ren_a[target];
        end
        OFF_SEL:   rd_next = DATA_W'(sel_a[target]);
        OFF_IDENT: rd_next = DATA_W'(target);
        OFF_CMP:   rd_next = DATA_W'(cmp_a[target]);
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_next;
    end
  end

  assert_upper_words_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd && (dec.cnt_hi || dec.usr_hi)) |=> (rd_data == '0));
  assert_user_copy_ro_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && dec.usr && stopped) |=> (count == $past(count)));
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
    rd |=> rd_valid);
endmodule

// File: tb/shared_cmp_timer_test.sv
module shared_cmp_timer_test;
  localparam int NC = 2;
  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [0:0]  req_core = '0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [NC*NP-1:0] irq_pin;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shared_cmp_timer #(.NUM_CORES(NC), .NUM_PINS(NP), .CNT_W(32)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_pin(irq_pin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int core, input logic [5:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_core = 1'(core);
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int core, input logic [5:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_core = 1'(core); req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rd_valid) begin
      tests++; fails++;
      $display("FAIL R12: actual rd_valid 0 expected 1");
    end
    d = rd_data;
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d cycles expected done", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq", 32'(irq_pin), 0);
    rd(0, 6'h00, v); chk("R10 cfg running", v, 0);
    for (int c = 0; c < NC; c++) begin
      rd(c, 6'h17, v); chk("R10 compare", v, 32'hFFFF_FFFF);
      rd(c, 6'h11, v); chk("R10 mask", v, 32'h32);
      rd(c, 6'h14, v); chk("R10 route", v, 32'h8000_0000);
      rd(c, 6'h10, v); chk("R10 pend", v, 0);
      rd(c, 6'h15, v); chk("R10 sel", v, 0);
    end
    rd(0, 6'h02, v); chk("R2 cnt hi", v, 0);
    rd(0, 6'h04, v); chk("R2 usr hi", v, 0);
    rd(0, 6'h18, v); chk("R2 cmp hi", v, 0);

    // R1 running increments once per clock
    rd(0, 6'h01, a); rd(0, 6'h01, b); chk("R1 step", b - a, 1);

    // R2 write while running ignored
    rd(0, 6'h01, a);
    wr(0, 6'h01, 32'd7);
    wr(0, 6'h00, 32'd1);
    rd(0, 6'h00, v); chk("R1 stop readback", v, 1);
    rd(0, 6'h01, b); chk("R2 running write ignored", b - a, 3);
    rd(0, 6'h01, v); chk("R1 hold when stopped", v, b);
    wr(0, 6'h01, 32'd1000);
    rd(0, 6'h01, v); chk("R2 load when stopped", v, 1000);

    // R9 user copy
    wr(0, 6'h03, 32'h99);
    rd(0, 6'h01, v); chk("R9 write ignored", v, 1000);
    rd(1, 6'h03, v); chk("R9 reads counter", v, 1000);

    // R3/R4/R5 sweep over every core and pin
    for (int c = 0; c < NC; c++) begin
      for (int p = 0; p < NP; p++) begin
        wr(0, 6'h00, 1);
        wr(0, 6'h01, 1000);
        for (int k = 0; k < NC; k++) wr(k, 6'h17, 32'hFFFF_FFF0);
        wr(c, 6'h17, 1003);
        wr(c, 6'h14, 32'h8000_0000 | 32'(p));
        repeat (2) @(negedge clk);
        chk("R3 no early pin", 32'(irq_pin), 0);
        wr(0, 6'h00, 0);
        repeat (12) @(negedge clk);
        chk("R4 routed pin", 32'(irq_pin), 32'(1) << (c*NP + p));
        rd(c, 6'h10, v); chk("R3 pend sticky", v, 2);
        wr(c, 6'h17, 32'hFFFF_FFF0);
        @(negedge clk);
        rd(c, 6'h10, v); chk("R5 pend cleared", v, 0);
        chk("R5 pin dropped", 32'(irq_pin), 0);
      end
    end

    // R6 mask set/clear with pending on core 0 pin 5
    wr(0, 6'h00, 1); wr(0, 6'h01, 50); wr(0, 6'h17, 50);
    @(negedge clk); @(negedge clk);
    chk("R4 pin while stopped at match", 32'(irq_pin), 32'(1) << 5);
    wr(0, 6'h12, 32'h02); @(negedge clk);
    chk("R6 clear hides pin", 32'(irq_pin), 0);
    rd(0, 6'h11, v); chk("R6 mask after clear", v, 32'h30);
    rd(0, 6'h10, v); chk("R6 pend kept", v, 2);
    wr(0, 6'h13, 32'h03); @(negedge clk);
    rd(0, 6'h11, v); chk("R6 mask after set", v, 32'h33);
    chk("R6 set restores pin", 32'(irq_pin), 32'(1) << 5);
    wr(0, 6'h14, 32'h0000_0005); @(negedge clk);
    chk("R4 route disabled", 32'(irq_pin), 0);

    // R11 route reject
    wr(0, 6'h14, 32'h8000_0006);
    rd(0, 6'h14, v); chk("R11 bad pin ignored", v, 32'h0000_0005);

    // R7/R8 remote window
    wr(0, 6'h15, 1);
    wr(0, 6'h27, 32'h1234);
    rd(1, 6'h17, v); chk("R7 remote write", v, 32'h1234);
    rd(0, 6'h17, v); chk("R7 local untouched", v, 50);
    wr(0, 6'h15, 2);
    rd(0, 6'h15, v); chk("R7 sel reject", v, 1);
    rd(0, 6'h26, v); chk("R8 ident remote", v, 1);
    rd(0, 6'h16, v); chk("R8 ident local", v, 0);
    rd(1, 6'h16, v); chk("R8 ident core1", v, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule